// File: doc/BRIEF.md
# ECC Error Reporting Register Block

This block is the software-visible side of an ECC-protected memory controller. A SECDED decoder reports each corrected single-bit error, each uncorrectable double-bit error and each correction that had to be dropped. Each report is a one-cycle pulse that comes with the failing address. The block turns these pulses into sticky status flags and two saturating 4-bit counters. It also keeps one captured error address, which serves both error classes. From the unmasked, enabled status it drives a single level interrupt line.

A control register drives the ECC enable and correction enable outputs. It also drives two injection requests to the write-path encoder: one asks for a single flipped check bit and one asks for two. The encoder applies a request to every store made while the request is set, so stores made earlier or later are stored clean. A later read of a corrupted word makes the decoder report the matching error. The register port is a plain single-cycle bus with combinational read data. The data-path width is a parameter and selects the code reported by the read-only width register.

Top module: `ecc_err_regs`

## Requirements
- R1: The control register at offset 0x00 holds bit 10 (ECC enable), bit 11 (correction enable), bit 13 (inject single-bit error) and bit 14 (inject double-bit error). These bits drive `ecc_en`, `corr_en`, `inj_single` and `inj_double` from the cycle after the write. All other bits read zero. Reset value is zero.
- R2: Offset 0x30 is read-only and returns 40 when DATA_W is 32 and 24 when DATA_W is 16. Writes to it are ignored.
- R3: Status at offset 0x38 has bit 2 for single-bit error, bit 3 for double-bit error and bit 4 for dropped correction. Each bit is set by its event pulse and stays set until a clear. Writes to 0x38 are ignored.
- R4: Offset 0x40 counts single-bit events and offset 0x44 counts double-bit events. Each counter is 4 bits wide and stops at 15 instead of wrapping.
- R5: Offset 0x48 returns the address that came with the most recent single-bit or double-bit event. A dropped-correction event leaves it unchanged.
- R6: The interrupt register at offset 0x3C holds bit 0 (global enable) and bits 1, 2 and 3, which mask the single-bit, double-bit and dropped sources. Bit 4 is a write-one clear and always reads zero.
- R7: `irq` is high exactly when the global enable is set and a status flag is set whose mask bit is zero.
- R8: A write to 0x3C with bit 4 set clears all status flags and both counters. After that write the interrupt enable equals bit 0 of the same write.
- R9: An event that arrives in the same cycle as a clear wins. Its flag ends set and its counter ends at 1.
- R10: Reads of any offset not listed above return zero.
- R11: A word stored while an injection bit is set reads back later with the matching error. A word stored after the bit is cleared reads back clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of a read access |
| ev_sbe | input | 1 | Single-bit error pulse from the decoder |
| ev_dbe | input | 1 | Double-bit error pulse from the decoder |
| ev_drop | input | 1 | Dropped-correction pulse from the decoder |
| ev_addr | input | ERR_ADDR_W | Failing address that comes with an event |
| ecc_en | output | 1 | ECC enable to the controller |
| corr_en | output | 1 | Correction enable to the decoder |
| inj_single | output | 1 | Request one corrupted check bit on stores |
| inj_double | output | 1 | Request two corrupted check bits on stores |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after four corner cases.

- Clear and event in the same cycle. A design in which the clear takes priority would read back a zero flag and a zero count.
- Seventeen back-to-back single-bit events. A counter that wraps would read back 0 or 1 instead of 15.
- A dropped-correction event after a double-bit event. A block that captures the address on every source would overwrite the shared address.
- The clear bit written alone and written together with the enable. A block that keeps the old enable across a clear would leave the interrupt armed when it should be off.

Injection is checked end to end through a small memory model in the bench that remembers which stores were corrupted. A design whose control bits reach the encoder late, or affect the wrong class, would produce a missing or mismatched error.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;
   localparam int REG_W   = 32;
   localparam int OFS_W   = 8;
   localparam int N_SRC   = 3;
   localparam int CHK_BITS = 8;

   // source order inside the event vector; status and mask fields follow it
   localparam int SRC_SBE  = 0;
   localparam int SRC_DBE  = 1;
   localparam int SRC_DROP = 2;

   localparam logic [OFS_W-1:0] OFS_CTRL  = 8'h00;
   localparam logic [OFS_W-1:0] OFS_WIDTH = 8'h30;
   localparam logic [OFS_W-1:0] OFS_STAT  = 8'h38;
   localparam logic [OFS_W-1:0] OFS_INTR  = 8'h3C;
   localparam logic [OFS_W-1:0] OFS_SBCNT = 8'h40;
   localparam logic [OFS_W-1:0] OFS_DBCNT = 8'h44;
   localparam logic [OFS_W-1:0] OFS_EADDR = 8'h48;

   localparam int CTRL_ECC_BIT  = 10;
   localparam int CTRL_CORR_BIT = 11;
   localparam int CTRL_INJ1_BIT = 13;
   localparam int CTRL_INJ2_BIT = 14;

   localparam int STAT_LSB      = 2;
   localparam int INTR_EN_BIT   = 0;
   localparam int INTR_MASK_LSB = 1;
   localparam int INTR_CLR_BIT  = 4;

   typedef struct packed {
      logic inj_double;
      logic inj_single;
      logic corr_en;
      logic ecc_en;
   } ctrl_t;
endpackage

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 1) begin : g_bad_cnt
      $error("ecc_sat_counter: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] base;

   // a clear zeroes the base; an increment in the same cycle still lands
   assign base = clr ? '0 : cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (inc) begin
         cnt <= (base == CNT_MAX) ? base : base + 1'b1;
      end else begin
         cnt <= base;
      end
   end
endmodule

// File: rtl/ecc_err_status.sv
module ecc_err_status #(
   parameter int N_SRC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [N_SRC-1:0] ev,
   input  logic             int_en,
   input  logic [N_SRC-1:0] mask,
   output logic [N_SRC-1:0] flags,
   output logic             irq
);
   logic [N_SRC-1:0] pend;

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags[g] <= 1'b0;
         end else if (ev[g]) begin
            flags[g] <= 1'b1;
         end else if (clr) begin
            flags[g] <= 1'b0;
         end
      end
      assign pend[g] = flags[g] & ~mask[g];
   end

   assign irq = int_en & (|pend);
endmodule

// File: rtl/ecc_err_regs.sv
module ecc_err_regs
   import ecc_regs_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 4,
   parameter int ERR_ADDR_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_sel,
   input  logic                  reg_we,
   input  logic [7:0]            reg_addr,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata,
   input  logic                  ev_sbe,
   input  logic                  ev_dbe,
   input  logic                  ev_drop,
   input  logic [ERR_ADDR_W-1:0] ev_addr,
   output logic                  ecc_en,
   output logic                  corr_en,
   output logic                  inj_single,
   output logic                  inj_double,
   output logic                  irq
);
   localparam int N_CNT = 2;

   if (ERR_ADDR_W < 1 || ERR_ADDR_W > REG_W) begin : g_bad_addr
      $error("ecc_err_regs: ERR_ADDR_W must lie in 1..32");
   end
   if (CNT_W < 1 || CNT_W > REG_W) begin : g_bad_cnt
      $error("ecc_err_regs: CNT_W must lie in 1..32");
   end

   // interface-width code: data bits plus check bits
   logic [7:0] width_code;
   if (DATA_W == 32) begin : g_w32
      assign width_code = 8'(DATA_W + CHK_BITS);
   end else if (DATA_W == 16) begin : g_w16
      assign width_code = 8'(DATA_W + CHK_BITS);
   end else begin : g_wbad
      $error("ecc_err_regs: DATA_W must be 16 or 32");
      assign width_code = '0;
   end

   logic wr, wr_ctrl, wr_intr, clr;
   assign wr      = reg_sel & reg_we;
   assign wr_ctrl = wr && (reg_addr == OFS_CTRL);
   assign wr_intr = wr && (reg_addr == OFS_INTR);
   assign clr     = wr_intr & reg_wdata[INTR_CLR_BIT];

   ctrl_t            ctrl_q;
   logic             int_en;
   logic [N_SRC-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q.ecc_en     <= reg_wdata[CTRL_ECC_BIT];
         ctrl_q.corr_en    <= reg_wdata[CTRL_CORR_BIT];
         ctrl_q.inj_single <= reg_wdata[CTRL_INJ1_BIT];
         ctrl_q.inj_double <= reg_wdata[CTRL_INJ2_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_en <= 1'b0;
         mask_q <= '0;
      end else if (wr_intr) begin
         int_en <= reg_wdata[INTR_EN_BIT];
         mask_q <= reg_wdata[INTR_MASK_LSB +: N_SRC];
      end
   end

   assign ecc_en     = ctrl_q.ecc_en;
   assign corr_en    = ctrl_q.corr_en;
   assign inj_single = ctrl_q.inj_single;
   assign inj_double = ctrl_q.inj_double;

   logic [N_SRC-1:0] ev_vec;
   logic [N_SRC-1:0] flags;
   assign ev_vec[SRC_SBE]  = ev_sbe;
   assign ev_vec[SRC_DBE]  = ev_dbe;
   assign ev_vec[SRC_DROP] = ev_drop;

   ecc_err_status #(.N_SRC(N_SRC)) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .ev     (ev_vec),
      .int_en (int_en),
      .mask   (mask_q),
      .flags  (flags),
      .irq    (irq)
   );

   logic [CNT_W-1:0] cnt_arr [N_CNT];
   for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
      ecc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr),
         .inc   (ev_vec[g]),
         .cnt   (cnt_arr[g])
      );
   end

   logic [CNT_W-1:0] sbe_cnt, dbe_cnt;
   assign sbe_cnt = cnt_arr[SRC_SBE];
   assign dbe_cnt = cnt_arr[SRC_DBE];

   // one address register serves both error classes
   logic [ERR_ADDR_W-1:0] err_addr;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_addr <= '0;
      end else if (ev_sbe | ev_dbe) begin
         err_addr <= ev_addr;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_sel && !reg_we) begin
         unique case (reg_addr)
            OFS_CTRL: begin
               reg_rdata[CTRL_ECC_BIT]  = ctrl_q.ecc_en;
               reg_rdata[CTRL_CORR_BIT] = ctrl_q.corr_en;
               reg_rdata[CTRL_INJ1_BIT] = ctrl_q.inj_single;
               reg_rdata[CTRL_INJ2_BIT] = ctrl_q.inj_double;
            end
            OFS_WIDTH: reg_rdata[7:0] = width_code;
            OFS_STAT:  reg_rdata[STAT_LSB +: N_SRC] = flags;
            OFS_INTR: begin
               reg_rdata[INTR_EN_BIT] = int_en;
               reg_rdata[INTR_MASK_LSB +: N_SRC] = mask_q;
            end
            OFS_SBCNT: reg_rdata[CNT_W-1:0] = sbe_cnt;
            OFS_DBCNT: reg_rdata[CNT_W-1:0] = dbe_cnt;
            OFS_EADDR: reg_rdata[ERR_ADDR_W-1:0] = err_addr;
            default:   reg_rdata = '0;
         endcase
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^{reg_wdata[31:15], reg_wdata[12], reg_wdata[9:5]};
endmodule

// File: rtl/ecc_err_regs_chk.sv
module ecc_err_regs_chk
   import ecc_regs_pkg::*;
#(
   parameter int CNT_W      = 4,
   parameter int ERR_ADDR_W = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_sel,
   input logic                  reg_we,
   input logic [7:0]            reg_addr,
   input logic [31:0]           reg_wdata,
   input logic                  ev_sbe,
   input logic                  ev_dbe,
   input logic                  ev_drop,
   input logic [ERR_ADDR_W-1:0] ev_addr,
   input logic                  irq,
   input logic                  int_en,
   input logic [N_SRC-1:0]      mask_q,
   input logic [N_SRC-1:0]      flags,
   input logic [CNT_W-1:0]      sbe_cnt,
   input logic [CNT_W-1:0]      dbe_cnt,
   input logic [ERR_ADDR_W-1:0] err_addr
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic intr_wr, clr_wr, any_ev;
   assign intr_wr = reg_sel && reg_we && (reg_addr == OFS_INTR);
   assign clr_wr  = intr_wr && reg_wdata[INTR_CLR_BIT];
   assign any_ev  = ev_sbe || ev_dbe || ev_drop;

   a_r4_sbe_holds_max: assert property (@(posedge clk) disable iff (!rst_n)
      (sbe_cnt == CMAX && !clr_wr) |=> (sbe_cnt == CMAX));
   a_r4_dbe_holds_max: assert property (@(posedge clk) disable iff (!rst_n)
      (dbe_cnt == CMAX && !clr_wr) |=> (dbe_cnt == CMAX));
   a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> ((flags & $past(flags)) == $past(flags)));
   a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !any_ev) |=> (flags == '0 && sbe_cnt == '0 && dbe_cnt == '0));
   a_r9_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && ev_sbe) |=> (flags[SRC_SBE] && sbe_cnt == CNT_W'(1)));
   a_r7_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !int_en |-> !irq);
   a_r7_sbe_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (int_en && ev_sbe && !mask_q[SRC_SBE] && !intr_wr) |=> irq);
   a_r7_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '1) |-> !irq);
   a_r5_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_sbe || ev_dbe) |=> (err_addr == $past(ev_addr)));
   a_r5_drop_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_drop && !ev_sbe && !ev_dbe) |=> $stable(err_addr));
endmodule

bind ecc_err_regs ecc_err_regs_chk #(.CNT_W(CNT_W), .ERR_ADDR_W(ERR_ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_sel   (reg_sel),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .ev_sbe    (ev_sbe),
   .ev_dbe    (ev_dbe),
   .ev_drop   (ev_drop),
   .ev_addr   (ev_addr),
   .irq       (irq),
   .int_en    (int_en),
   .mask_q    (mask_q),
   .flags     (flags),
   .sbe_cnt   (sbe_cnt),
   .dbe_cnt   (dbe_cnt),
   .err_addr  (err_addr)
);

// File: tb/tb_ecc_err_regs.sv
module tb_ecc_err_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0, reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ev_sbe = 1'b0, ev_dbe = 1'b0, ev_drop = 1'b0;
   logic [31:0] ev_addr = '0;
   logic        ecc_en, corr_en, inj_single, inj_double, irq;

   int checks = 0;
   int fails  = 0;

   typedef struct {
      logic [7:0]  a;
      logic [31:0] e;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   logic [1:0] mem_bad [16];

   always #2 clk = ~clk;

   ecc_err_regs dut (
      .clk(clk), .rst_n(rst_n),
      .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_sbe(ev_sbe), .ev_dbe(ev_dbe), .ev_drop(ev_drop), .ev_addr(ev_addr),
      .ecc_en(ecc_en), .corr_en(corr_en), .inj_single(inj_single),
      .inj_double(inj_double), .irq(irq)
   );

   // monitor: pops one expected item per read cycle, compares away from the edge
   always @(negedge clk) begin
      if (reg_sel && !reg_we) begin
         checks++;
         if (sb_q.size() == 0) begin
            fails++;
            $display("FAIL scoreboard: read at %h with nothing expected (actual %h expected none)",
                     reg_addr, reg_rdata);
         end else begin
            exp_t it;
            it = sb_q.pop_front();
            if (reg_rdata !== it.e || reg_addr !== it.a) begin
               fails++;
               $display("FAIL %s: offset %h actual %h expected %h", it.tag, it.a, reg_rdata, it.e);
            end
         end
      end
   end

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
      sb_q.push_back('{a, e, tag});
      @(posedge clk); #1;
      reg_sel = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_sel = 1'b0; reg_we = 1'b0;
   endtask

   task automatic pulse(input logic s, input logic d, input logic p, input logic [31:0] a);
      ev_sbe = s; ev_dbe = d; ev_drop = p; ev_addr = a;
      @(posedge clk); #1;
      ev_sbe = 1'b0; ev_dbe = 1'b0; ev_drop = 1'b0;
   endtask

   task automatic chk(input logic act, input logic e, input string tag);
      checks++;
      if (act !== e) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", tag, act, e);
      end
   endtask

   // memory model standing in for the encoder and decoder
   task automatic store(input int idx);
      mem_bad[idx] = {inj_double, inj_single};
      @(posedge clk); #1;
   endtask

   task automatic load(input int idx);
      logic [31:0] a;
      a = 32'h8000_0000 + 32'(idx * 4);
      if (mem_bad[idx][1])      pulse(1'b0, 1'b1, 1'b0, a);
      else if (mem_bad[idx][0]) pulse(1'b1, 1'b0, 1'b0, a);
      else begin @(posedge clk); #1; end
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) mem_bad[i] = 2'b00;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // reset state
      rd(8'h00, 32'h0, "R1 ctrl reset");
      rd(8'h38, 32'h0, "R3 status reset");
      rd(8'h3C, 32'h0, "R6 intr reset");
      rd(8'h40, 32'h0, "R4 sbe count reset");
      rd(8'h44, 32'h0, "R4 dbe count reset");
      rd(8'h48, 32'h0, "R5 address reset");
      chk(irq, 1'b0, "R7 irq reset");

      // R1 control bits
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, 32'h0000_6C00, "R1 ctrl only defined bits");
      chk(inj_single, 1'b1, "R1 inj_single set");
      chk(inj_double, 1'b1, "R1 inj_double set");
      wr(8'h00, 32'h0000_0C00);
      chk(ecc_en, 1'b1, "R1 ecc_en");
      chk(corr_en, 1'b1, "R1 corr_en");
      chk(inj_single, 1'b0, "R1 inj_single cleared");
      chk(inj_double, 1'b0, "R1 inj_double cleared");

      // R2 width, R3 status read-only
      wr(8'h30, 32'h0);
      rd(8'h30, 32'd40, "R2 width code");
      wr(8'h38, 32'hFF);
      rd(8'h38, 32'h0, "R3 status ignores writes");

      // R6 interrupt register fields
      wr(8'h3C, 32'h1F);
      rd(8'h3C, 32'h0F, "R6 clear bit reads zero");
      wr(8'h3C, 32'h01);

      // R10 holes
      rd(8'h04, 32'h0, "R10 hole 0x04");
      rd(8'h34, 32'h0, "R10 hole 0x34");
      rd(8'h4C, 32'h0, "R10 hole 0x4C");

      // single then double error share the address register
      pulse(1'b1, 1'b0, 1'b0, 32'h0000_1000);
      chk(irq, 1'b1, "R7 sbe raises irq");
      rd(8'h38, 32'h04, "R3 sbe flag");
      rd(8'h40, 32'd1, "R4 sbe count one");
      rd(8'h48, 32'h0000_1000, "R5 sbe address");
      pulse(1'b0, 1'b1, 1'b0, 32'h0000_2000);
      rd(8'h38, 32'h0C, "R3 sbe and dbe flags");
      rd(8'h44, 32'd1, "R4 dbe count one");
      rd(8'h48, 32'h0000_2000, "R5 shared address overwritten");

      // R8 clear with enable
      wr(8'h3C, 32'h11);
      rd(8'h38, 32'h0, "R8 status cleared");
      rd(8'h40, 32'h0, "R8 sbe count cleared");
      rd(8'h44, 32'h0, "R8 dbe count cleared");
      rd(8'h3C, 32'h01, "R8 enable kept");
      chk(irq, 1'b0, "R8 irq low after clear");

      // dropped correction, masking, clear alone
      pulse(1'b0, 1'b0, 1'b1, 32'h0000_3000);
      rd(8'h38, 32'h10, "R3 drop flag");
      rd(8'h48, 32'h0000_2000, "R5 drop keeps address");
      chk(irq, 1'b1, "R7 drop raises irq");
      wr(8'h3C, 32'h09);
      chk(irq, 1'b0, "R7 drop masked");
      wr(8'h3C, 32'h10);
      rd(8'h3C, 32'h0, "R8 clear alone disables");
      rd(8'h38, 32'h0, "R8 clear alone empties status");

      // R4 saturation
      for (int i = 0; i < 17; i++) pulse(1'b1, 1'b0, 1'b0, 32'h0000_4000);
      rd(8'h40, 32'd15, "R4 sbe count saturates");
      chk(irq, 1'b0, "R7 irq off while disabled");
      wr(8'h3C, 32'h01);
      chk(irq, 1'b1, "R7 irq after enable");

      // R9 event and clear in one cycle
      reg_sel = 1'b1; reg_we = 1'b1; reg_addr = 8'h3C; reg_wdata = 32'h11;
      ev_sbe = 1'b1; ev_addr = 32'h0000_5000;
      @(posedge clk); #1;
      reg_sel = 1'b0; reg_we = 1'b0; ev_sbe = 1'b0;
      rd(8'h38, 32'h04, "R9 flag survives clear");
      rd(8'h40, 32'd1, "R9 count restarts at one");
      rd(8'h44, 32'd0, "R9 other count cleared");
      chk(irq, 1'b1, "R9 irq stays");

      // R11 injection end to end
      wr(8'h3C, 32'h11);
      wr(8'h00, 32'h0000_2C00);
      store(3);
      wr(8'h00, 32'h0000_0C00);
      store(4);
      load(4);
      rd(8'h38, 32'h0, "R11 clean store reads clean");
      chk(irq, 1'b0, "R11 no irq on clean word");
      load(3);
      rd(8'h38, 32'h04, "R11 single injection flagged");
      rd(8'h48, 32'h8000_000C, "R11 single injection address");
      chk(irq, 1'b1, "R11 irq on injected word");
      wr(8'h00, 32'h0000_4C00);
      store(5);
      wr(8'h00, 32'h0000_0C00);
      load(5);
      rd(8'h38, 32'h0C, "R11 double injection flagged");
      rd(8'h44, 32'd1, "R11 double injection counted");
      rd(8'h48, 32'h8000_0014, "R11 double injection address");

      @(posedge clk); #1;
      if (sb_q.size() != 0) begin
         checks++; fails++;
         $display("FAIL scoreboard: %0d reads unmatched (actual pending, expected 0)", sb_q.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule